// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a management host access to a space of 32 devices by 32 registers of 16 bits while showing only two 16-bit registers at its own device address. Register 0 is the command register and register 1 is the data register. The host loads the data register, then writes a command word that names an operation, a target device and a target register. The bridge raises a busy flag for a fixed, short number of cycles and then performs the access. A write copies the data register into the internal register. A read loads the data register from it.

A strap input selects the mode. A strap value of zero puts the bridge in direct mode. Every host access then goes straight to the internal register named by its own device and register fields, and no command is involved. Any other strap value is the bridge's own device address in indirect mode. The internal array is modelled in the block and is cleared by reset. The strap is treated as static while an operation is in flight.

Top module: `regspace_bridge`

## Requirements
- R1: After reset the busy flag is 0, the command and data registers read 0, and every internal register reads 0.
- R2: In indirect mode, a write to register 0 of the strap device while idle starts an operation when bits 15:10 equal 6'b100110 (read) or 6'b100101 (write). Bits 9:5 name the device and bits 4:0 name the register. Bit 15 of register 0 then reads 1.
- R3: Busy stays set for exactly BUSY_CYCLES clock cycles after the edge that accepted the command, then clears.
- R4: A write operation copies the data register into the addressed internal register in the cycle that busy clears.
- R5: After a read operation clears busy, register 1 holds the addressed internal register. Register 1 does not change while busy is set.
- R6: A command written while busy is ignored. The running operation completes on its original target.
- R7: A data-register write while busy is ignored.
- R8: A command word whose bits 15:10 match neither opcode is ignored. Busy stays 0 and register 0 keeps its value.
- R9: In indirect mode, accesses to any device other than the strap address are ignored and read as 0. Registers 2 to 31 of the strap device also read as 0.
- R10: With strap 0, a host write updates internal register (device, register) at that clock edge. A host read returns that register in the same cycle. Busy never rises.
- R11: Register 0 reads as {busy, bits 14:0 of the last accepted command}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr | input | 5 | Bridge device address; 0 selects direct mode |
| host_req | input | 1 | Single-cycle access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_dev | input | 5 | Device field of the host access |
| host_reg | input | 5 | Register field of the host access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_dev/host_reg, combinational |

## Verification
A wrong busy counter shows in register 0 within BUSY_CYCLES+1 cycles of a command: bit 15 clears too early, too late or never. A corrupt latched target or opcode shows only when the affected register is read back, through a later read command or a direct access. A data register that is overwritten during busy shows in the value written to the array at the end of that same operation.

// File: rtl/regbridge_pkg.sv
// Shared constants and types of the indirect register access bridge.
package regbridge_pkg;
    localparam int DEV_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int OPC_W  = DATA_W - DEV_W - REG_W;

    localparam logic [OPC_W-1:0] OPC_READ  = 6'b100110;
    localparam logic [OPC_W-1:0] OPC_WRITE = 6'b100101;

    typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE} op_e;

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [REG_W-1:0] rg;
    } tgt_t;
endpackage

// File: rtl/regbridge_cmd_decode.sv
// Splits a command word into an operation and a target.
// Assumes: the opcode sits in the bits above the device and register fields.
module regbridge_cmd_decode
    import regbridge_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    output op_e               op,
    output tgt_t              tgt
);
    // opcode match and field split
    always_comb begin
        tgt.dev = word[DEV_W+REG_W-1:REG_W];
        tgt.rg  = word[REG_W-1:0];
        if (word[DATA_W-1:DEV_W+REG_W] == OPC_READ)
            op = OP_READ;
        else if (word[DATA_W-1:DEV_W+REG_W] == OPC_WRITE)
            op = OP_WRITE;
        else
            op = OP_NONE;
    end
endmodule

// File: rtl/regbridge_busy_timer.sv
// Holds busy for BUSY_CYCLES cycles after start and pulses done in the last one.
// Assumes: start is only raised while busy is low; BUSY_CYCLES >= 1.
module regbridge_busy_timer #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == CW'(1));

    // countdown of the remaining busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt  <= cnt - CW'(1);
        end
    end

    // checker: length of the current busy run
    logic [CW:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else            run_len <= '0;
    end

    p_busy_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= (CW+1)'(BUSY_CYCLES))
        else $error("busy held longer than BUSY_CYCLES");
    p_busy_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && run_len != '0) |-> run_len == (CW+1)'(BUSY_CYCLES))
        else $error("busy released early");
endmodule

// File: rtl/regbridge_reg_array.sv
// Internal register space: one write port, two combinational read ports.
// Assumes: the index is {device, register}; reset clears every entry.
module regbridge_reg_array
    import regbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  tgt_t              wtgt,
    input  logic [DATA_W-1:0] wdata,
    input  tgt_t              rtgt_a,
    output logic [DATA_W-1:0] rdata_a,
    input  tgt_t              rtgt_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << (DEV_W + REG_W);

    logic [DATA_W-1:0] mem [DEPTH];

    // storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wtgt] <= wdata;
        end
    end

    assign rdata_a = mem[rtgt_a];
    assign rdata_b = mem[rtgt_b];
endmodule

// File: rtl/regspace_bridge.sv
// Indirect register access bridge: a command/data pair at device strap_addr
// reaches a 32x32x16 internal space; strap_addr == 0 maps the space directly.
// Assumes: strap_addr does not change while an operation is in flight.
module regspace_bridge
    import regbridge_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  strap_addr,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [DEV_W-1:0]  host_dev,
    input  logic [REG_W-1:0]  host_reg,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam logic [REG_W-1:0] CMD_REG  = REG_W'(0);
    localparam logic [REG_W-1:0] DATA_REG = REG_W'(1);

    logic              direct, at_bridge, hit_cmd, hit_data, start;
    logic              busy, done;
    logic [DATA_W-2:0] cmd_q;
    logic [DATA_W-1:0] data_q;
    op_e               op_q, new_op;
    tgt_t              tgt_q, new_tgt, host_tgt, mem_wtgt;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata, mem_op_rd, mem_host_rd;

    assign direct    = (strap_addr == '0);
    assign at_bridge = !direct && host_req && host_we && (host_dev == strap_addr);
    assign hit_cmd   = at_bridge && (host_reg == CMD_REG);
    assign hit_data  = at_bridge && (host_reg == DATA_REG);
    assign start     = hit_cmd && !busy && (new_op != OP_NONE);
    assign host_tgt  = '{dev: host_dev, rg: host_reg};

    regbridge_cmd_decode u_dec (
        .word (host_wdata),
        .op   (new_op),
        .tgt  (new_tgt)
    );

    regbridge_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    // latch the accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            op_q  <= OP_NONE;
            tgt_q <= '0;
        end else if (start) begin
            cmd_q <= host_wdata[DATA_W-2:0];
            op_q  <= new_op;
            tgt_q <= new_tgt;
        end
    end

    // data register: host load when idle, read result at completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (done && op_q == OP_READ)
            data_q <= mem_op_rd;
        else if (hit_data && !busy)
            data_q <= host_wdata;
    end

    // array write port: direct host write or completing bridge write
    always_comb begin
        if (direct && host_req && host_we) begin
            mem_we    = 1'b1;
            mem_wtgt  = host_tgt;
            mem_wdata = host_wdata;
        end else begin
            mem_we    = done && (op_q == OP_WRITE);
            mem_wtgt  = tgt_q;
            mem_wdata = data_q;
        end
    end

    regbridge_reg_array u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .wtgt    (mem_wtgt),
        .wdata   (mem_wdata),
        .rtgt_a  (tgt_q),
        .rdata_a (mem_op_rd),
        .rtgt_b  (host_tgt),
        .rdata_b (mem_host_rd)
    );

    // host read mux
    always_comb begin
        if (direct)
            host_rdata = mem_host_rd;
        else if (host_dev != strap_addr)
            host_rdata = '0;
        else if (host_reg == CMD_REG)
            host_rdata = {busy, cmd_q};
        else if (host_reg == DATA_REG)
            host_rdata = data_q;
        else
            host_rdata = '0;
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct && host_req && host_we && host_dev == strap_addr && host_reg == CMD_REG
         && !busy && (host_wdata[DATA_W-1:DEV_W+REG_W] == OPC_READ
                   || host_wdata[DATA_W-1:DEV_W+REG_W] == OPC_WRITE)) |=> busy)
        else $error("valid command did not raise busy");
    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cmd_q) && $stable(tgt_q) && $stable(op_q)))
        else $error("command changed during busy");
    p_data_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data_q))
        else $error("data register changed during busy");
    p_direct_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (direct && !busy) |=> !busy)
        else $error("busy rose in direct mode");
    p_bad_opcode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cmd && !busy && new_op == OP_NONE) |=> (!busy && $stable(cmd_q)))
        else $error("invalid opcode accepted");
endmodule

// File: tb/test_regspace_bridge.sv
module test_regspace_bridge;
    localparam int N = 4;
    localparam logic [4:0] S = 5'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_addr = S;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_dev = '0;
    logic [4:0]  host_reg = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    regspace_bridge #(.BUSY_CYCLES(N)) i_regspace_bridge (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
        .host_req(host_req), .host_we(host_we), .host_dev(host_dev),
        .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    // {device, register, data}
    localparam logic [25:0] VEC [8] = '{
        {5'd0,  5'd0,  16'h0001}, {5'd1,  5'd2,  16'hA5A5},
        {5'd31, 5'd31, 16'hFFFF}, {5'd3,  5'd0,  16'h5A5A},
        {5'd3,  5'd1,  16'h1357}, {5'd16, 5'd8,  16'h8000},
        {5'd7,  5'd30, 16'h00FF}, {5'd12, 5'd17, 16'hC3C3}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_dev = d; host_reg = r; host_wdata = v;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic hrd(input logic [4:0] d, input logic [4:0] r, output logic [15:0] v);
        host_dev = d; host_reg = r;
        #1;
        v = host_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [15:0] v;
        n = 0;
        hrd(S, 5'd0, v);
        while (v[15] && n < 100) begin
            n++;
            @(negedge clk);
            hrd(S, 5'd0, v);
        end
    endtask

    function automatic logic [15:0] cmd(input logic wr, input logic [4:0] d, input logic [4:0] r);
        return (wr ? 16'h9400 : 16'h9800) | {6'd0, d, r};
    endfunction

    task automatic bridge_write(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v);
        int n;
        hwr(S, 5'd1, v);
        hwr(S, 5'd0, cmd(1'b1, d, r));
        wait_idle(n);
    endtask

    task automatic bridge_read(input logic [4:0] d, input logic [4:0] r, output logic [15:0] v);
        int n;
        hwr(S, 5'd0, cmd(1'b0, d, r));
        wait_idle(n);
        hrd(S, 5'd1, v);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int n;
        do_reset();

        // R1 reset state
        hrd(S, 5'd0, v); check("R1 cmd reg", v, 16'h0000);
        hrd(S, 5'd1, v); check("R1 data reg", v, 16'h0000);
        bridge_read(5'd5, 5'd7, v); check("R1 array zero", v, 16'h0000);

        // R4 R5 vector walk: write then read back through the bridge
        for (int i = 0; i < 8; i++) begin
            bridge_write(VEC[i][25:21], VEC[i][20:16], VEC[i][15:0]);
            hwr(S, 5'd1, 16'h0BAD);
            bridge_read(VEC[i][25:21], VEC[i][20:16], v);
            check("R4 R5 vector", v, VEC[i][15:0]);
        end

        // R2 R3 R11 busy length and command readback
        hwr(S, 5'd0, cmd(1'b0, 5'd1, 5'd2));
        hrd(S, 5'd0, v); check("R2 busy on start", v, cmd(1'b0, 5'd1, 5'd2));
        wait_idle(n);
        check("R3 busy cycles", 16'(n), 16'(N));
        hrd(S, 5'd0, v); check("R11 cmd readback", v, cmd(1'b0, 5'd1, 5'd2) & 16'h7FFF);
        hrd(S, 5'd1, v); check("R5 read result", v, 16'hA5A5);

        // R6 command during busy ignored
        hwr(S, 5'd1, 16'hAAAA);
        hwr(S, 5'd0, cmd(1'b1, 5'd9, 5'd9));
        hwr(S, 5'd0, cmd(1'b1, 5'd10, 5'd10));
        wait_idle(n);
        hrd(S, 5'd0, v); check("R6 cmd unchanged", v, cmd(1'b1, 5'd9, 5'd9) & 16'h7FFF);
        bridge_read(5'd9, 5'd9, v);   check("R6 original target", v, 16'hAAAA);
        bridge_read(5'd10, 5'd10, v); check("R6 second target", v, 16'h0000);

        // R7 data write during busy ignored
        hwr(S, 5'd1, 16'h1234);
        hwr(S, 5'd0, cmd(1'b1, 5'd4, 5'd4));
        hwr(S, 5'd1, 16'hFFFF);
        wait_idle(n);
        hrd(S, 5'd1, v); check("R7 data reg kept", v, 16'h1234);
        bridge_read(5'd4, 5'd4, v); check("R7 written value", v, 16'h1234);

        // R8 invalid opcode
        hwr(S, 5'd0, 16'h8000 | {6'd0, 5'd4, 5'd4});
        hrd(S, 5'd0, v); check("R8 no busy, cmd kept", v, cmd(1'b0, 5'd4, 5'd4) & 16'h7FFF);

        // R9 other device ignored and reads 0
        hwr(S, 5'd1, 16'h2222);
        hwr(5'd7, 5'd1, 16'h7777);
        hrd(S, 5'd1, v);    check("R9 data untouched", v, 16'h2222);
        hrd(5'd7, 5'd1, v); check("R9 other dev reads 0", v, 16'h0000);
        hrd(S, 5'd5, v);    check("R9 unused reg reads 0", v, 16'h0000);

        // R10 direct mode
        strap_addr = 5'd0;
        do_reset();
        hwr(5'd9, 5'd3, 16'hBEEF);
        hrd(5'd9, 5'd3, v); check("R10 direct readback", v, 16'hBEEF);
        hwr(5'd0, 5'd0, cmd(1'b1, 5'd9, 5'd3));
        hrd(5'd0, 5'd0, v); check("R10 plain register", v, cmd(1'b1, 5'd9, 5'd3));
        repeat (N + 2) @(negedge clk);
        hrd(5'd9, 5'd3, v); check("R10 no operation", v, 16'hBEEF);
        strap_addr = S;
        @(negedge clk);
        hrd(S, 5'd0, v); check("R10 never busy", v, 16'h0000);
        bridge_read(5'd9, 5'd3, v); check("R10 direct data via bridge", v, 16'hBEEF);

        finish_run();
    end
endmodule